// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a peripheral bus clock into the two timing strobes an asynchronous serial port needs: a sample strobe at the oversampling rate and a bit strobe at the bit rate. The divide ratio is an integer divisor plus a fraction counted in eighths of a clock. The fraction is realised by stretching some sample periods by one clock. A phase accumulator chooses which periods are stretched, so the average period equals the fractional divisor. A mode bit sets the bit period to 16 or 8 sample periods.

A serial transmitter shifts one bit on each bit strobe. A receiver uses the sample strobes to find the middle of each bit. Any change to the divisor, the fraction, the mode or the enable restarts the generator cleanly. A clean restart never emits a short period or two periods merged into one. An integer divisor of zero, or a low enable, stops both strobes.

Top module: `frac_baud_gen`

## Requirements
- R1: With `ovs_sel`=0 (16x) every bit period lasts exactly 16*`div_int` + 2*`div_frac` clocks.
- R2: With `ovs_sel`=1 (8x) every bit period lasts exactly 8*`div_int` + `div_frac` clocks. The sample counter never reaches the oversampling factor.
- R3: Every sample period lasts `div_int` or `div_int`+1 clocks. With `div_frac`=0 every sample period lasts `div_int` clocks.
- R4: `div_frac` is a 3-bit field counting eighths of a clock. Starting from a restart, each group of 8 consecutive sample periods contains exactly `div_frac` periods of `div_int`+1 clocks. A stretched period always ends with the period counter equal to `div_int`.
- R5: With `div_int`=5, `div_frac`=7 and 16x mode, the bit period is 94 clocks. At a 24 MHz clock this gives about 255319 baud.
- R6: With `div_int`=13, `div_frac`=0 and 16x mode, the bit period is 208 clocks. At a 24 MHz clock this gives about 115385 baud.
- R7: While `div_int`=0 or `en`=0, neither strobe is ever high.
- R8: Between two consecutive bit strobes there are exactly 16 (16x mode) or 8 (8x mode) sample strobes, the closing one included.
- R9: `bit_tick` is high only in a cycle where `sample_tick` is also high.
- R10: A clock edge that sees a changed `div_int`, `div_frac`, `ovs_sel` or `en` restarts the generator. Counting that edge as edge 1, the first bit strobe appears after edge number equal to one full bit period of the new setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_int | input | 16 | Integer divisor; 0 stops the generator |
| div_frac | input | 3 | Fraction of the divisor in eighths |
| ovs_sel | input | 1 | 0: 16 samples per bit, 1: 8 samples per bit |
| en | input | 1 | Generator enable |
| sample_tick | output | 1 | One-clock strobe per sample period |
| bit_tick | output | 1 | One-clock strobe per bit period |

## Verification
The bench runs through small divisors (1, 2, 3, 5, 13) and every fraction 0 to 7 in both oversampling modes. It applies each setting directly after the previous one, so every run also tests a restart in the middle of a period. Each run checks:
- the latency to the first bit strobe, which separates a clean restart from a truncated or merged period;
- every bit interval against the exact clock count;
- every sample interval, and the number of stretched periods in the first eight, which shows whether the accumulator places the fraction correctly.

Divisor 1 with a nonzero fraction tests the one-clock period, where strobes fall on back-to-back cycles. The two 24 MHz operating points, a zero divisor and a low enable complete the set.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
    localparam int DEF_CD_W = 16;
    localparam int DEF_FP_W = 3;
    localparam int SAMP_W   = 4;

    typedef enum logic {
        OVS_X16 = 1'b0,
        OVS_X8  = 1'b1
    } ovs_e;
endpackage

// File: rtl/frac_phase_acc.sv
module frac_phase_acc #(
    parameter int FP_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    input  logic [FP_W-1:0] frac,
    output logic            stretch
);
    typedef struct packed {
        logic [FP_W-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [FP_W:0] sum;

    always_comb begin
        sum     = {1'b0, st_q.acc} + {1'b0, frac};
        stretch = sum[FP_W];
        st_d    = st_q;
        if (clear)
            st_d.acc = '0;
        else if (step)
            st_d.acc = sum[FP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_acc_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> st_q.acc == '0);
endmodule

// File: rtl/baud_period_ctr.sv
module baud_period_ctr #(
    parameter int CD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            active,
    input  logic [CD_W-1:0] div_int,
    input  logic            stretch,
    output logic            tick
);
    typedef struct packed {
        logic [CD_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;
    logic [CD_W-1:0] last_val;

    always_comb begin
        last_val = stretch ? div_int : div_int - 1'b1;
        tick     = active && !clear && (st_q.cnt == last_val);
        st_d     = st_q;
        if (clear || tick)
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clear) |-> st_q.cnt <= div_int);
    assert_stretch_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && stretch) |-> st_q.cnt == div_int);
    assert_cnt_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> st_q.cnt == '0);
endmodule

// File: rtl/sample_div_ctr.sv
module sample_div_ctr
    import frac_baud_pkg::*;
#(
    parameter int SW = SAMP_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  ovs_e ovs,
    output logic bit_out
);
    localparam logic [SW-1:0] LAST_X16 = SW'((1 << SW) - 1);
    localparam logic [SW-1:0] LAST_X8  = SW'((1 << (SW - 1)) - 1);

    typedef struct packed {
        logic [SW-1:0] samp;
    } samp_st_t;

    samp_st_t st_d, st_q;
    logic at_last;

    always_comb begin
        at_last = (st_q.samp == ((ovs == OVS_X8) ? LAST_X8 : LAST_X16));
        bit_out = step && at_last;
        st_d    = st_q;
        if (clear || bit_out)
            st_d.samp = '0;
        else if (step)
            st_d.samp = st_q.samp + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_samp_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovs == OVS_X8 && !clear) |-> st_q.samp <= LAST_X8);
    assert_samp_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> st_q.samp == '0);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int CD_W = DEF_CD_W,
    parameter int FP_W = DEF_FP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CD_W-1:0] div_int,
    input  logic [FP_W-1:0] div_frac,
    input  logic            ovs_sel,
    input  logic            en,
    output logic            sample_tick,
    output logic            bit_tick
);
    typedef struct packed {
        logic            active;
        logic [CD_W-1:0] cd;
        logic [FP_W-1:0] fp;
        logic            ovs;
    } cfg_t;

    cfg_t cfg_now, cfg_d, cfg_q;
    logic active, changed, clear, stretch;
    ovs_e ovs;

    always_comb begin
        active  = en && (div_int != '0);
        cfg_now = '{active: active, cd: div_int, fp: div_frac, ovs: ovs_sel};
        changed = (cfg_now != cfg_q);
        clear   = changed || !active;
        ovs     = ovs_e'(ovs_sel);
        cfg_d   = cfg_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    frac_phase_acc #(.FP_W(FP_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .step    (sample_tick),
        .frac    (div_frac),
        .stretch (stretch)
    );

    baud_period_ctr #(.CD_W(CD_W)) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .active  (active),
        .div_int (div_int),
        .stretch (stretch),
        .tick    (sample_tick)
    );

    sample_div_ctr #(.SW(SAMP_W)) u_samp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .step    (sample_tick),
        .ovs     (ovs),
        .bit_out (bit_tick)
    );

    assert_off_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || div_int == '0) |-> (!sample_tick && !bit_tick));
    assert_bit_on_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);
endmodule

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div_int = '0;
    logic [2:0]  div_frac = '0;
    logic        ovs_sel = 1'b0;
    logic        en = 1'b0;
    logic        sample_tick, bit_tick;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    frac_baud_gen dut (
        .clk(clk), .rst_n(rst_n), .div_int(div_int), .div_frac(div_frac),
        .ovs_sel(ovs_sel), .en(en), .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply one setting and observe three bit periods.
    task automatic run_cfg(input int cd, input int fp, input bit o8, output int first_bit);
        int bitp, nsamp, t, last_s, last_b, nbits, s_in_bit, s_idx, longs;
        bitp = o8 ? (8*cd + fp) : (16*cd + 2*fp);
        nsamp = o8 ? 8 : 16;
        @(negedge clk);
        div_int = 16'(cd); div_frac = 3'(fp); ovs_sel = o8; en = 1'b1;
        last_s = 0; last_b = 0; nbits = 0; s_in_bit = 0; s_idx = 0; longs = 0;
        first_bit = -1;
        t = 0;
        while (nbits < 3 && t < 4*bitp + 20) begin
            @(posedge clk); @(negedge clk); t++;
            if (bit_tick && !sample_tick)
                check(1'b0, "R9 bit without sample", 1, 0);
            if (sample_tick) begin
                int iv;
                iv = t - last_s;
                last_s = t;
                s_in_bit++;
                s_idx++;
                check(iv == cd || iv == cd + 1, "R3 sample interval", iv, cd);
                if (fp == 0 && iv != cd)
                    check(1'b0, "R3 no stretch when fraction zero", iv, cd);
                if (s_idx <= 8 && iv == cd + 1) longs++;
                if (s_idx == 8)
                    check(longs == fp, "R4 stretched periods per eight", longs, fp);
            end
            if (bit_tick) begin
                if (nbits == 0) begin
                    first_bit = t;
                    check(t == bitp, "R10 first bit after restart", t, bitp);
                end else begin
                    check(t - last_b == bitp, o8 ? "R2 bit period 8x" : "R1 bit period 16x",
                          t - last_b, bitp);
                end
                check(s_in_bit == nsamp, "R8 samples per bit", s_in_bit, nsamp);
                s_in_bit = 0;
                last_b = t;
                nbits++;
            end
        end
        check(nbits == 3, "R1 R2 bit strobes seen", nbits, 3);
    endtask

    task automatic expect_silent(input string req, input int cycles);
        int hits;
        hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); @(negedge clk);
            if (sample_tick || bit_tick) hits++;
        end
        check(hits == 0, req, hits, 0);
    endtask

    initial begin
        int fb;
        int cds[5] = '{1, 2, 3, 5, 13};
        #5;
        check(!sample_tick && !bit_tick, "R7 reset state quiet", int'(sample_tick), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_silent("R7 enable low", 20);

        for (int o = 0; o < 2; o++)
            for (int c = 0; c < 5; c++)
                for (int f = 0; f < 8; f++)
                    run_cfg(cds[c], f, o[0], fb);

        run_cfg(5, 7, 1'b0, fb);
        check(fb == 94, "R5 CD=5 FP=7 bit period", fb, 94);
        run_cfg(13, 0, 1'b0, fb);
        check(fb == 208, "R6 CD=13 FP=0 bit period", fb, 208);

        @(negedge clk); div_int = 16'd0;
        expect_silent("R7 divisor zero", 60);
        @(negedge clk); div_int = 16'd3; en = 1'b0;
        expect_silent("R7 enable low with divisor", 60);
        // re-enable behaves like any other restart
        run_cfg(3, 5, 1'b1, fb);
        check(fb == 29, "R10 re-enable latency", fb, 29);
        done = 1'b1;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
    end

    initial begin
        wait (done || n_chk < 0);
        fork
            wait (done);
            begin repeat (150001) @(posedge clk); end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule